// File: doc/BRIEF.md
# Processor Bring-Up Register Bank

This block is the small register file a host processor uses to start an attached compute core. The host sets the core's first instruction address in one register. It then walks the core out of reset through a control register in two writes. The first write opens the core's clock enable while the core's reset stays asserted. The second write drops the reset. The core then starts fetching at the programmed address. A read-only word reports whether the core has stopped and whether it has faulted.

The block also controls the core's clock enable outside software's direct command. While the core signals that it is waiting for an interrupt, the enable is withdrawn, and an active-low interrupt line brings it back. An internal guard keeps the core's synchronous reset from ending before the core has seen at least one enabled clock with reset applied. The guard covers the case where software writes the two control values back to back, or skips the first one.

Top module: `boot_ctrl_regs`

## Requirements
- R1: While the system reset `rst_n` is low at a clock edge, and after that edge, `core_rst` is 1, `core_clk_en` is 0 and `core_start_pc` is 0. A read of offset 0x0 then returns 3, and a read of offset 0x4 returns 0.
- R2: Control word offset 0x0 has bit 0 as reset hold and bit 1 as clock-gate closed. Writing 1 to it leaves `core_rst` at 1 and, with no wait condition, sets `core_clk_en` to 1 from the next cycle.
- R3: After the core has had an enabled reset cycle, writing 0 to offset 0x0 drops `core_rst` to 0 in the next cycle. At that point `core_start_pc` holds the programmed start address.
- R4: `core_rst` never falls unless `core_clk_en` was 1 in the cycle before the fall. Writing 0 directly after a value of 3 therefore keeps `core_rst` high for exactly one enabled cycle, and a wait condition stretches that cycle.
- R5: A read of offset 0x8 returns `core_halted` in bit 0 and `core_fault` in bit 1, with all other bits 0.
- R6: A write to offset 0x8 changes no register, and its response has `reg_err` at 0.
- R7: An access to any offset other than 0x0, 0x4 or 0x8 returns `reg_rdata` of 0 with `reg_err` at 1, and a write to such an offset changes no register.
- R8: While `core_wfi` is 1 and `core_irq_n` is 1, `core_clk_en` is 0. When `core_irq_n` is 0, the enable follows the gate bit again.
- R9: Offset 0x4 holds a full-width start address that reads back as written and drives `core_start_pc`.
- R10: `reg_rdata` and `reg_err` respond in the cycle after the access strobe and are 0 in any cycle that follows no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| reg_err | output | 1 | Undefined-offset flag, one cycle after the strobe |
| core_halted | input | 1 | Core reports it has stopped |
| core_fault | input | 1 | Core reports a fault |
| core_wfi | input | 1 | Core waits for an interrupt |
| core_irq_n | input | 1 | Active-low interrupt to the core |
| core_rst | output | 1 | Active-high synchronous reset to the core |
| core_clk_en | output | 1 | Enable for the core's clock gate |
| core_start_pc | output | PC_W | Start address for the core |

## Verification
The assertions assume the host never raises `reg_rd` and `reg_wr` in the same cycle. They also assume that `core_wfi` and `core_irq_n` change only between clock edges. The bench drives every input a short delay after the rising edge and issues one access per task call, so both assumptions hold. The core-side inputs are free bench variables, so a wait condition can land while the reset guard is still pending, which the R4 and R8 checks rely on.

// File: rtl/boot_ctrl_regs.sv
module boot_ctrl_regs #(
  parameter int ADDR_W = 8,
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] PC_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_err,
  input  logic              core_halted,
  input  logic              core_fault,
  input  logic              core_wfi,
  input  logic              core_irq_n,
  output logic              core_rst,
  output logic              core_clk_en,
  output logic [PC_W-1:0]   core_start_pc
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_PC   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(8);
  localparam int PC_RD_W = (PC_W < 32) ? PC_W : 32;

  logic [1:0] ctrl_q;
  logic [PC_W-1:0] pc_q;
  logic owed_q;

  wire hold_rst  = ctrl_q[0];
  wire gate_shut = ctrl_q[1];
  wire hit_ctrl  = reg_addr == OFS_CTRL;
  wire hit_pc    = reg_addr == OFS_PC;
  wire hit_stat  = reg_addr == OFS_STAT;
  wire hit_any   = hit_ctrl | hit_pc | hit_stat;
  wire asleep    = core_wfi & core_irq_n;

  assign core_clk_en   = ~gate_shut & ~asleep;
  assign core_rst      = hold_rst | owed_q;
  assign core_start_pc = pc_q;

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) rd_mux[1:0] = ctrl_q;
    else if (hit_pc) rd_mux[PC_RD_W-1:0] = pc_q[PC_RD_W-1:0];
    else if (hit_stat) rd_mux[1:0] = {core_fault, core_halted};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= 2'b11;
      pc_q      <= PC_RESET;
      owed_q    <= 1'b1;
      reg_rdata <= '0;
      reg_err   <= 1'b0;
    end else begin
      if (core_rst && core_clk_en) owed_q <= 1'b0;
      else if (hold_rst && !core_clk_en) owed_q <= 1'b1;
      if (reg_wr && hit_ctrl) ctrl_q <= reg_wdata[1:0];
      if (reg_wr && hit_pc) pc_q <= PC_W'(reg_wdata);
      reg_rdata <= reg_rd ? rd_mux : '0;
      reg_err   <= (reg_rd | reg_wr) & ~hit_any;
    end
  end
endmodule

// File: rtl/boot_ctrl_regs_chk.sv
module boot_ctrl_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int PC_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              reg_err,
  input logic              core_wfi,
  input logic              core_irq_n,
  input logic              core_rst,
  input logic              core_clk_en,
  input logic [PC_W-1:0]   core_start_pc
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (core_rst && !core_clk_en));

  a_r2_gate_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0 && reg_wdata[1:0] == 2'b01)
      |=> (core_rst && (core_clk_en || (core_wfi && core_irq_n))));

  a_r4_rst_min_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> $past(core_clk_en));

  a_r6_status_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(8)) |=> (!reg_err && $stable(core_start_pc)));

  a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> reg_rdata == '0);

  a_r8_wfi_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wfi && core_irq_n) |-> !core_clk_en);

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_rd || reg_wr) |-> (reg_rdata == '0 && !reg_err));
endmodule

bind boot_ctrl_regs boot_ctrl_regs_chk #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .reg_err(reg_err), .core_wfi(core_wfi), .core_irq_n(core_irq_n),
  .core_rst(core_rst), .core_clk_en(core_clk_en), .core_start_pc(core_start_pc)
);

// File: tb/boot_ctrl_regs_tb.sv
module boot_ctrl_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_err;
  logic core_halted = 1'b0, core_fault = 1'b0, core_wfi = 1'b0, core_irq_n = 1'b1;
  logic core_rst, core_clk_en;
  logic [31:0] core_start_pc;

  always #4 clk = ~clk;

  boot_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_err(reg_err), .core_halted(core_halted), .core_fault(core_fault),
    .core_wfi(core_wfi), .core_irq_n(core_irq_n), .core_rst(core_rst),
    .core_clk_en(core_clk_en), .core_start_pc(core_start_pc)
  );

  int vectors = 0, miscompares = 0;
  string cur_req = "R1";
  bit done = 0;

  logic [1:0] m_ctrl = 2'b11;
  logic [31:0] m_pc = '0, m_rdata = '0;
  bit m_owed = 1, m_err = 0;

  function automatic bit m_en();
    return !m_ctrl[1] && !(core_wfi && core_irq_n);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 2'b11; m_pc = '0; m_owed = 1; m_rdata = '0; m_err = 0;
    end else begin
      bit en, rs;
      en = m_en();
      rs = m_ctrl[0] || m_owed;
      if (rs && en) m_owed = 0;
      else if (m_ctrl[0] && !en) m_owed = 1;
      m_rdata = '0; m_err = 0;
      if (reg_wr) begin
        case (reg_addr)
          8'h00: m_ctrl = reg_wdata[1:0];
          8'h04: m_pc = reg_wdata;
          8'h08: ;
          default: m_err = 1;
        endcase
      end
      if (reg_rd) begin
        case (reg_addr)
          8'h00: m_rdata = {30'b0, m_ctrl};
          8'h04: m_rdata = m_pc;
          8'h08: m_rdata = {30'b0, core_fault, core_halted};
          default: m_err = 1;
        endcase
      end
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      cmp("core_rst", 32'(core_rst), 32'(m_ctrl[0] || m_owed));
      cmp("core_clk_en", 32'(core_clk_en), 32'(m_en()));
      cmp("core_start_pc", core_start_pc, m_pc);
      cmp("reg_rdata", reg_rdata, m_rdata);
      cmp("reg_err", 32'(reg_err), 32'(m_err));
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a);
    @(posedge clk); #2;
    reg_rd = 1; reg_addr = a;
    @(posedge clk); #2;
    reg_rd = 0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    idle(3);
    rst_n = 1;
    rd(8'h00); rd(8'h04);
    cur_req = "R9";
    wr(8'h04, 32'h0000_1000); rd(8'h04);
    wr(8'h04, 32'hDEAD_BEEC); rd(8'h04);
    cur_req = "R2";
    wr(8'h00, 32'h1); idle(2); rd(8'h00);
    cur_req = "R3";
    wr(8'h00, 32'h0); idle(2); rd(8'h00);
    cur_req = "R5";
    core_halted = 1; rd(8'h08);
    core_halted = 0; core_fault = 1; rd(8'h08);
    core_halted = 1; rd(8'h08);
    core_halted = 0; core_fault = 0; rd(8'h08);
    cur_req = "R6";
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h00); rd(8'h04);
    cur_req = "R7";
    rd(8'h0C); rd(8'h02); rd(8'hFC);
    wr(8'h0C, 32'h3); wr(8'h05, 32'h0); rd(8'h00); rd(8'h04);
    cur_req = "R10";
    idle(3);
    cur_req = "R8";
    core_wfi = 1; idle(3);
    core_irq_n = 0; idle(2);
    core_irq_n = 1; idle(1);
    core_wfi = 0; idle(2);
    cur_req = "R4";
    wr(8'h00, 32'h3); idle(1);
    wr(8'h00, 32'h0); idle(3);
    wr(8'h00, 32'h3); wr(8'h00, 32'h1); wr(8'h00, 32'h0); idle(2);
    wr(8'h00, 32'h3); core_wfi = 1; wr(8'h00, 32'h0); idle(3);
    core_irq_n = 0; idle(2);
    core_irq_n = 1; core_wfi = 0; idle(2);
    cur_req = "R1";
    wr(8'h04, 32'h40); wr(8'h00, 32'h2);
    rst_n = 0; idle(2); rst_n = 1;
    rd(8'h00); rd(8'h04); idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule